// File: doc/BRIEF.md
# Length-Selected Serial Register Port

This block is a three-wire synchronous serial slave. A host drives serial data, a serial clock and an active-low enable. While enable is low, bits enter a 24-bit shift register on each rising serial clock edge, most significant bit first, and a bit counter tracks how many arrived. When enable returns high, the transfer length alone decides where the data goes. No address or steering bits are used. The data can go to an 8-bit configuration register, to a 24-bit display register, or nowhere.

A serial data output presents the oldest bit of the shift register. It updates on the falling serial clock edge, so the path behaves as 24 and a half stages. Two or more ports can therefore be chained: each output feeds the next input, and all ports share the clock and enable. In a chain of two, a 32-bit stream writes both configuration registers and a 48-bit stream writes both display registers. The far port receives the earlier part of the stream.

All three serial inputs are oversampled in one system clock domain through two-flop synchronisers. Edges are detected from the synchronised copies. Each enable rising edge also gives a one-cycle blanking strobe that a display scanner can use while new data settles.

Top module: `lenreg_port`

## Requirements
- R1: While enable is low and the port is in step, each rising serial clock edge shifts the data input into bit 0 of the shift register and moves every other bit up by one. The first bit sent therefore ends up most significant.
- R2: The serial output changes only on a falling serial clock edge, or when enable is high. On a falling edge it takes bit 23 of the shift register. A second port fed from this output receives the stream 24 bits later.
- R3: While enable is high, the serial output is low, the shift register and bit count are cleared, and serial clock edges have no effect on the next transfer.
- R4: At an enable rising edge, if the number of bits shifted, counted modulo 24, equals 8, the configuration register takes the last 8 bits received. Examples are 8 and 32 bits.
- R5: At an enable rising edge, if a non-zero number of bits that is a multiple of 24 was shifted, the display register takes the last 24 bits received, with the first of them in bit 23.
- R6: At an enable rising edge after any other bit count, including zero and every short aborted transfer, neither register changes.
- R7: The configuration and display outputs change only in the cycle in which the blanking strobe is high. The strobe is high for exactly one cycle per synchronised enable rising edge, and never during shifting.
- R8: An enable edge that is seen while the serial clock is high puts the port out of step. It then ignores clock edges and commits nothing until enable is high while the clock is low, after which transfers work normally again.
- R9: After reset, both registers read zero and the serial output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdi_i | input | 1 | Serial data input |
| sclk_i | input | 1 | Serial clock |
| sen_ni | input | 1 | Active-low transfer enable |
| sdo_o | output | 1 | Serial data output for chaining |
| cfg_o | output | CFG_W (8) | Configuration register |
| dsp_o | output | DSP_W (24) | Display register |
| blank_o | output | 1 | One-cycle strobe on each enable rising edge |

## Verification
The assertions assume that each serial clock and enable level lasts at least three system clocks. Under that assumption the synchronisers never merge or drop an edge, and two enable rising edges can never fall in adjacent cycles. The bench holds every serial clock phase and every enable level for four or more system clocks. It moves enable while the clock is high only in the directed step that tests losing and regaining step. Random lengths and data drive two chained ports, and the expected register values are computed from the stream at each port's depth in the chain.

// File: rtl/lenreg_pkg.sv
package lenreg_pkg;

    typedef enum logic [1:0] {
        CMT_NONE = 2'd0,
        CMT_CFG  = 2'd1,
        CMT_DSP  = 2'd2
    } commit_e;

    // Decide the target from the bit count held modulo the display width.
    function automatic commit_e classify(input int unsigned phase,
                                         input logic         any_bits,
                                         input int unsigned  cfg_w);
        if (!any_bits)            return CMT_NONE;
        else if (phase == 0)      return CMT_DSP;
        else if (phase == cfg_w)  return CMT_CFG;
        else                      return CMT_NONE;
    endfunction

endpackage

// File: rtl/lenreg_sync.sv
module lenreg_sync #(
    parameter int unsigned     N      = 3,
    parameter int unsigned     STAGES = 2,
    parameter logic [N-1:0]    RST    = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= {STAGES{RST[b]}};
            else         chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/lenreg_shift.sv
module lenreg_shift
    import lenreg_pkg::*;
#(
    parameter int unsigned CFG_W = 8,
    parameter int unsigned DSP_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sdi_s,
    input  logic             sclk_s,
    input  logic             sen_s,
    output logic [DSP_W-1:0] shreg_o,
    output commit_e          kind_o,
    output logic             armed_o,
    output logic             en_rise_o,
    output logic             sdo_o
);

    localparam int unsigned PW = $clog2(DSP_W);

    typedef struct packed {
        logic [DSP_W-1:0] sh;
        logic [PW-1:0]    phase;
        logic             any_bits;
        logic             armed;
        logic             sdo;
        logic             sclk_p;
        logic             sen_p;
    } state_t;

    state_t st_d, st_q;
    logic   sclk_rise, sclk_fall, en_edge;

    always_comb begin
        sclk_rise = sclk_s & ~st_q.sclk_p;
        sclk_fall = ~sclk_s & st_q.sclk_p;
        en_edge   = sen_s ^ st_q.sen_p;

        st_d        = st_q;
        st_d.sclk_p = sclk_s;
        st_d.sen_p  = sen_s;

        // Step tracking: an enable edge with clock high loses step.
        if (sen_s && !sclk_s)        st_d.armed = 1'b1;
        else if (en_edge && sclk_s)  st_d.armed = 1'b0;

        if (sen_s) begin
            st_d.sh       = '0;
            st_d.phase    = '0;
            st_d.any_bits = 1'b0;
            st_d.sdo      = 1'b0;
        end else if (st_q.armed) begin
            if (sclk_rise) begin
                st_d.sh       = {st_q.sh[DSP_W-2:0], sdi_s};
                st_d.any_bits = 1'b1;
                st_d.phase    = (st_q.phase == PW'(DSP_W - 1)) ? '0 : st_q.phase + 1'b1;
            end
            if (sclk_fall) begin
                st_d.sdo = st_q.sh[DSP_W-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{sh: '0, phase: '0, any_bits: 1'b0, armed: 1'b0,
                               sdo: 1'b0, sclk_p: 1'b0, sen_p: 1'b1};
        else         st_q <= st_d;
    end

    assign shreg_o   = st_q.sh;
    assign kind_o    = classify(int'(st_q.phase), st_q.any_bits, CFG_W);
    assign armed_o   = st_q.armed;
    assign en_rise_o = sen_s & ~st_q.sen_p;
    assign sdo_o     = st_q.sdo;

endmodule

// File: rtl/lenreg_commit.sv
module lenreg_commit
    import lenreg_pkg::*;
#(
    parameter int unsigned CFG_W = 8,
    parameter int unsigned DSP_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_rise,
    input  logic             sclk_s,
    input  logic             armed,
    input  commit_e          kind,
    input  logic [DSP_W-1:0] shreg,
    output logic [CFG_W-1:0] cfg_o,
    output logic [DSP_W-1:0] dsp_o,
    output logic             blank_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [DSP_W-1:0] dsp;
        logic             blank;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d       = rg_q;
        rg_d.blank = en_rise;
        if (en_rise && armed && !sclk_s) begin
            unique case (kind)
                CMT_CFG: rg_d.cfg = shreg[CFG_W-1:0];
                CMT_DSP: rg_d.dsp = shreg;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end

    assign cfg_o   = rg_q.cfg;
    assign dsp_o   = rg_q.dsp;
    assign blank_o = rg_q.blank;

endmodule

// File: rtl/lenreg_port.sv
module lenreg_port
    import lenreg_pkg::*;
#(
    parameter int unsigned CFG_W  = 8,
    parameter int unsigned DSP_W  = 24,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sdi_i,
    input  logic             sclk_i,
    input  logic             sen_ni,
    output logic             sdo_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [DSP_W-1:0] dsp_o,
    output logic             blank_o
);

    localparam int unsigned NIN = 3;

    logic [NIN-1:0]   sync_w;
    logic             sdi_s, sclk_s, sen_s;
    logic [DSP_W-1:0] shreg_w;
    commit_e          kind_w;
    logic             armed_w, en_rise_w;

    lenreg_sync #(.N(NIN), .STAGES(STAGES), .RST(3'b100)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({sen_ni, sclk_i, sdi_i}),
        .sync_o  (sync_w)
    );

    assign sen_s  = sync_w[2];
    assign sclk_s = sync_w[1];
    assign sdi_s  = sync_w[0];

    lenreg_shift #(.CFG_W(CFG_W), .DSP_W(DSP_W)) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sdi_s     (sdi_s),
        .sclk_s    (sclk_s),
        .sen_s     (sen_s),
        .shreg_o   (shreg_w),
        .kind_o    (kind_w),
        .armed_o   (armed_w),
        .en_rise_o (en_rise_w),
        .sdo_o     (sdo_o)
    );

    lenreg_commit #(.CFG_W(CFG_W), .DSP_W(DSP_W)) u_commit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_rise (en_rise_w),
        .sclk_s  (sclk_s),
        .armed   (armed_w),
        .kind    (kind_w),
        .shreg   (shreg_w),
        .cfg_o   (cfg_o),
        .dsp_o   (dsp_o),
        .blank_o (blank_o)
    );

endmodule

// File: rtl/lenreg_port_chk.sv
module lenreg_port_chk #(
    parameter int unsigned CFG_W = 8,
    parameter int unsigned DSP_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sen_s,
    input logic             sclk_s,
    input logic             sdo_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic [DSP_W-1:0] dsp_o,
    input logic             blank_o
);

    // R7: register outputs move only together with the blanking strobe
    a_r7_hold_between_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !blank_o |-> ($stable(cfg_o) && $stable(dsp_o)));

    // R7: the strobe lasts a single cycle
    a_r7_blank_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank_o |=> !blank_o);

    // R3: enable high forces the serial output low
    a_r3_sdo_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sen_s |=> !sdo_o);

    // R2: output changes only after a clock fall or with enable high
    a_r2_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sdo_o) |-> ($past(sen_s) || (!$past(sclk_s) && $past(sclk_s, 2))));

endmodule

bind lenreg_port lenreg_port_chk #(.CFG_W(CFG_W), .DSP_W(DSP_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sen_s   (sen_s),
    .sclk_s  (sclk_s),
    .sdo_o   (sdo_o),
    .cfg_o   (cfg_o),
    .dsp_o   (dsp_o),
    .blank_o (blank_o)
);

// File: tb/lenreg_port_tb_top.sv
module lenreg_port_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0, sclk = 1'b0, sen_n = 1'b1;
    logic sdo_a, sdo_b, blank_a, blank_b;
    logic [7:0]  cfg_a, cfg_b;
    logic [23:0] dsp_a, dsp_b;
    logic [7:0]  ecfg_a = '0, ecfg_b = '0;
    logic [23:0] edsp_a = '0, edsp_b = '0;
    int checks = 0, errors = 0, blanks = 0;

    always #10 clk = ~clk;

    lenreg_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sdi_i(sdi), .sclk_i(sclk), .sen_ni(sen_n),
        .sdo_o(sdo_a), .cfg_o(cfg_a), .dsp_o(dsp_a), .blank_o(blank_a));

    lenreg_port dut2_i (
        .clk_i(clk), .rst_ni(rst_n), .sdi_i(sdo_a), .sclk_i(sclk), .sen_ni(sen_n),
        .sdo_o(sdo_b), .cfg_o(cfg_b), .dsp_o(dsp_b), .blank_o(blank_b));

    always @(posedge clk) if (blank_a) blanks <= blanks + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sdi = b;  wait_clk(4);
        sclk = 1; wait_clk(4);
        sclk = 0; wait_clk(4);
    endtask

    // Expected commit for a port at a given chain depth (R4, R5, R6).
    task automatic model(input logic [63:0] v, input int n, input int depth,
                         inout logic [7:0] c, inout logic [23:0] d);
        logic [63:0] seen;
        seen = v >> (24 * depth);
        if (n > 0 && n % 24 == 0)      d = seen[23:0];
        else if (n % 24 == 8)          c = seen[7:0];
    endtask

    task automatic check_all(input string req);
        chk({req, " near cfg"}, 32'(cfg_a), 32'(ecfg_a));
        chk({req, " near dsp"}, 32'(dsp_a), 32'(edsp_a));
        chk({req, " far cfg"},  32'(cfg_b), 32'(ecfg_b));
        chk({req, " far dsp"},  32'(dsp_b), 32'(edsp_b));
    endtask

    task automatic send(input logic [63:0] v, input int n, input string req);
        sen_n = 1'b0; wait_clk(4);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
        sen_n = 1'b1; wait_clk(8);
        model(v, n, 0, ecfg_a, edsp_a);
        model(v, n, 1, ecfg_b, edsp_b);
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int b0;
        logic [63:0] v;
        int n;
        void'($urandom(32'd2024));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R9 reset state
        chk("R9 cfg", 32'(cfg_a), 0);
        chk("R9 dsp", 32'(dsp_a), 0);
        chk("R9 sdo", 32'(sdo_a), 0);

        // R4 single config write, R5 display write, any order
        send(64'hC3, 8, "R4 cfg8");
        send(64'h9A5F21, 24, "R5 dsp24");
        send(64'h5E, 8, "R4 cfg8 again");

        // R1 R2: serial output shows MSB of shift register after each fall
        sen_n = 1'b0; wait_clk(4);
        for (int i = 23; i >= 0; i--) bit_out(i[0] ^ i[2]);
        chk("R2 sdo first bit", 32'(sdo_a), 32'(1'b1 ^ 1'b1 ^ 1'b0)); // bit 23: 1^1
        bit_out(1'b0);
        chk("R1 sdo second bit", 32'(sdo_a), 32'(1'b0 ^ 1'b1));       // bit 22: 0^1
        sen_n = 1'b1; wait_clk(8);
        check_all("R6 count 25");
        chk("R3 sdo idle", 32'(sdo_a), 0);

        // R7: no change mid transfer, one strobe per enable rise
        b0 = blanks;
        sen_n = 1'b0; wait_clk(4);
        for (int i = 0; i < 12; i++) bit_out(1'b1);
        chk("R7 mid dsp", 32'(dsp_a), 32'(edsp_a));
        chk("R7 mid cfg", 32'(cfg_a), 32'(ecfg_a));
        chk("R7 no strobe mid", 32'(blanks - b0), 0);
        for (int i = 0; i < 12; i++) bit_out(1'b0);
        sen_n = 1'b1; wait_clk(8);
        model(64'hFFF000, 24, 0, ecfg_a, edsp_a);
        model(64'hFFF000, 24, 1, ecfg_b, edsp_b);
        check_all("R7 commit at rise");
        chk("R7 one strobe", 32'(blanks - b0), 1);

        // R6 aborted short transfers
        send(64'h15, 5, "R6 short 5");
        send(64'h2AB, 10, "R6 count 10");
        send(64'h0, 0, "R6 empty");

        // R3 clock edges with enable high are ignored
        for (int i = 0; i < 8; i++) bit_out(1'b1);
        send(64'h3C, 8, "R3 idle clocks ignored");

        // R8 enable falls while clock high: out of step, no commit
        sclk = 1'b1; wait_clk(4);
        sen_n = 1'b0; wait_clk(4);
        sclk = 1'b0; wait_clk(4);
        for (int i = 0; i < 8; i++) bit_out(1'b1);
        sen_n = 1'b1; wait_clk(8);
        check_all("R8 desync no commit");
        send(64'hA5, 8, "R8 resync write");

        // R4 R5 cascade: 32 and 48 bit streams
        send(64'h11223344, 32, "R4 cascade 32");
        send(64'hABCDEF123456, 48, "R5 cascade 48");

        // Random mix
        for (int k = 0; k < 24; k++) begin
            case ($urandom_range(0, 4))
                0: n = 8;
                1: n = 24;
                2: n = 32;
                3: n = 48;
                default: n = $urandom_range(1, 30);
            endcase
            v = {$urandom(), $urandom()};
            if (n < 64) v = v & ((64'd1 << n) - 64'd1);
            send(v, n, "R4 R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule